// File: doc/BRIEF.md
# Context-Tagged Address Translation Buffer

This block keeps a small, fully associative set of recent page translations in front of the page-table walker. Each lookup carries a virtual page number, a context identifier and an access kind. The buffer is searched before the walker is involved. A matching entry returns the physical page number, and the outcome of the rights check, in the same cycle. No memory traffic takes place on such a hit.

On a miss the block latches the request and asks the walker for the table entry. It holds that request until the walker acknowledges. A valid entry is written into the buffer and returned to the requester. An invalid entry is reported as a page fault and leaves the buffer untouched.

Every entry is tagged with its context, so entries from several address spaces can live side by side and a context switch needs no flush. Software can still drop everything at once, or only the entries of one context.

Top module: `ctx_tlb`

## Requirements
- R1: A lookup accepted while `req_ready` is high that matches a valid entry raises `resp_valid` and `resp_hit` in the same cycle, with the stored page number on `resp_ppn`, and no walk is started.
- R2: A lookup that matches no entry starts a walk: `walk_req` rises on the next cycle carrying the request's page number and context, and both stay stable until `walk_ack`. In the `walk_ack` cycle `resp_valid` is high with `resp_hit` low and `resp_ppn` equal to `walk_ppn`. A valid fetched entry is installed, so the same lookup then hits.
- R3: A hit needs both the page number and the context to match. The same page number under another context misses, and that other context's entry does not disturb the first one.
- R4: When the walker returns `walk_valid` low, `resp_fault` is high with the response and nothing is installed, so the same lookup walks again.
- R5: Rights are a 3-bit field: bit 0 allows read, bit 1 allows write, bit 2 allows execute. `req_kind` is 0 for read, 1 for write, 2 for execute, and 3 is never allowed. `resp_deny` is high when the kind's bit is clear, on hits (stored rights) and on filled misses (fetched rights).
- R6: A fill goes to the lowest-numbered invalid entry. When every entry is valid, it goes to the entry named by a round-robin pointer that starts at 0 after reset and advances by one, wrapping, after each such replacing fill.
- R7: `flush_all` invalidates every entry by the next cycle, including an entry being filled in that cycle.
- R8: `flush_ctx_en` invalidates only the entries whose context equals `flush_ctx_id`. Entries of other contexts keep hitting.
- R9: No two valid entries ever hold the same page number and context, so all `ENTRIES` slots hold distinct translations.
- R10: After reset every entry is invalid, `req_ready` is high, and `resp_valid` and `walk_req` are low.
- R11: While a walk is pending, `req_ready` is low and `req_valid` is ignored. A request presented then does not change the walk or the response, and is not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_ctx | input | CTX_W | Context identifier of the lookup |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| req_ready | output | 1 | Block idle and able to take a lookup |
| resp_valid | output | 1 | Response present this cycle |
| resp_hit | output | 1 | Response came from a stored entry |
| resp_ppn | output | PPN_W | Physical page number |
| resp_fault | output | 1 | Page fault: fetched entry invalid |
| resp_deny | output | 1 | Access kind not permitted by the rights |
| walk_req | output | 1 | Walk request to the page-table side |
| walk_vpn | output | VPN_W | Page number being walked |
| walk_ctx | output | CTX_W | Context being walked |
| walk_ack | input | 1 | Walker returns its result |
| walk_valid | input | 1 | Returned entry is valid |
| walk_ppn | input | PPN_W | Returned physical page number |
| walk_rights | input | 3 | Returned rights: bit 0 read, bit 1 write, bit 2 execute |
| flush_all | input | 1 | Invalidate every entry |
| flush_ctx_en | input | 1 | Invalidate entries of one context |
| flush_ctx_id | input | CTX_W | Context to invalidate |

## Verification
Some properties are checked by assertions on every cycle. At most one entry ever matches a lookup. A flush-all leaves no valid entry behind. A free slot is always chosen over replacing a valid one. The walk request stays steady until acknowledged. A fault never raises the number of valid entries. A fill without a flush leaves its slot valid.

Other behaviour can only be shown by the bench's scenarios:
- the round-robin replacement order once the buffer is full;
- the separation of contexts, and the selective context flush;
- the rights decision for each access kind;
- requests ignored while a walk is pending;
- the count of walks that reveals whether a lookup hit.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;

  localparam int RIGHTS_W = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } tlb_state_e;

  // rights bit 0 = read, bit 1 = write, bit 2 = execute; reserved kind never allowed
  function automatic logic rights_allow(input logic [RIGHTS_W-1:0] rights,
                                        input logic [1:0] kind);
    case (kind)
      ACC_READ:  return rights[0];
      ACC_WRITE: return rights[1];
      ACC_EXEC:  return rights[2];
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import ctx_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16,
  parameter int CTX_W   = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [VPN_W-1:0]    lk_vpn,
  input  logic [CTX_W-1:0]    lk_ctx,
  output logic [ENTRIES-1:0]  match_vec,
  output logic [ENTRIES-1:0]  valid_vec,
  output logic [PPN_W-1:0]    hit_ppn,
  output logic [RIGHTS_W-1:0] hit_rights,
  input  logic                fill_en,
  input  logic [IDX_W-1:0]    fill_idx,
  input  logic [VPN_W-1:0]    fill_vpn,
  input  logic [CTX_W-1:0]    fill_ctx,
  input  logic [PPN_W-1:0]    fill_ppn,
  input  logic [RIGHTS_W-1:0] fill_rights,
  input  logic                flush_all,
  input  logic                flush_ctx_en,
  input  logic [CTX_W-1:0]    flush_ctx_id
);

  logic [ENTRIES-1:0]  valid_q;
  logic [VPN_W-1:0]    vpn_q    [ENTRIES];
  logic [CTX_W-1:0]    ctx_q    [ENTRIES];
  logic [PPN_W-1:0]    ppn_q    [ENTRIES];
  logic [RIGHTS_W-1:0] rights_q [ENTRIES];

  logic [ENTRIES-1:0]  wr_vec;
  logic [ENTRIES-1:0]  kill_vec;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      logic [CTX_W-1:0] ctx_next;
      assign wr_vec[g]    = fill_en && (fill_idx == IDX_W'(g));
      assign ctx_next     = wr_vec[g] ? fill_ctx : ctx_q[g];
      // flush is judged on the context the slot will hold, so it beats a same-cycle fill
      assign kill_vec[g]  = flush_all || (flush_ctx_en && (ctx_next == flush_ctx_id));
      assign match_vec[g] = valid_q[g] && (vpn_q[g] == lk_vpn) && (ctx_q[g] == lk_ctx);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i]    <= '0;
        ctx_q[i]    <= '0;
        ppn_q[i]    <= '0;
        rights_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_vec[i]) begin
          vpn_q[i]    <= fill_vpn;
          ctx_q[i]    <= fill_ctx;
          ppn_q[i]    <= fill_ppn;
          rights_q[i] <= fill_rights;
        end
        valid_q[i] <= (valid_q[i] || wr_vec[i]) && !kill_vec[i];
      end
    end
  end

  always_comb begin
    hit_ppn    = '0;
    hit_rights = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        hit_ppn    = hit_ppn | ppn_q[i];
        hit_rights = hit_rights | rights_q[i];
      end
    end
  end

  assign valid_vec = valid_q;

  p_unique_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  p_flush_all_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0));

endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               advance,
  output logic               any_free,
  output logic [IDX_W-1:0]   victim_idx
);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;

  function automatic logic [IDX_W-1:0] lowest_free(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!v[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  function automatic logic [IDX_W-1:0] rr_next(input logic [IDX_W-1:0] cur);
    return (cur == IDX_W'(ENTRIES - 1)) ? '0 : cur + IDX_W'(1);
  endfunction

  assign any_free   = ~&valid_vec;
  assign free_idx   = lowest_free(valid_vec);
  assign victim_idx = any_free ? free_idx : rr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rr_q <= '0;
    else if (advance) rr_q <= rr_next(rr_q);
  end

  p_victim_prefers_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_free |-> !valid_vec[victim_idx]);

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import ctx_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16,
  parameter int CTX_W   = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [CTX_W-1:0] req_ctx,
  input  logic [1:0]       req_kind,
  output logic             req_ready,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic [PPN_W-1:0] resp_ppn,
  output logic             resp_fault,
  output logic             resp_deny,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  output logic [CTX_W-1:0] walk_ctx,
  input  logic             walk_ack,
  input  logic             walk_valid,
  input  logic [PPN_W-1:0] walk_ppn,
  input  logic [2:0]       walk_rights,
  input  logic             flush_all,
  input  logic             flush_ctx_en,
  input  logic [CTX_W-1:0] flush_ctx_id
);

  tlb_state_e       state_q;
  logic [VPN_W-1:0] pend_vpn_q;
  logic [CTX_W-1:0] pend_ctx_q;
  logic [1:0]       pend_kind_q;

  logic [VPN_W-1:0]    lk_vpn;
  logic [CTX_W-1:0]    lk_ctx;
  logic [ENTRIES-1:0]  match_vec;
  logic [ENTRIES-1:0]  valid_vec;
  logic [PPN_W-1:0]    hit_ppn;
  logic [RIGHTS_W-1:0] hit_rights;
  logic                lk_hit;
  logic [IDX_W-1:0]    match_idx;
  logic                any_free;
  logic [IDX_W-1:0]    victim_idx;

  // named internal events
  logic             accept_evt;
  logic             hit_evt;
  logic             miss_evt;
  logic             walk_done_evt;
  logic             fill_en;
  logic [IDX_W-1:0] fill_idx;
  logic             rr_advance;

  function automatic logic [IDX_W-1:0] onehot_index(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (v[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  // while walking, search on the pending request so a fill reuses any matching slot
  assign lk_vpn    = (state_q == ST_WALK) ? pend_vpn_q : req_vpn;
  assign lk_ctx    = (state_q == ST_WALK) ? pend_ctx_q : req_ctx;
  assign lk_hit    = |match_vec;
  assign match_idx = onehot_index(match_vec);

  assign accept_evt    = (state_q == ST_IDLE) && req_valid;
  assign hit_evt       = accept_evt && lk_hit;
  assign miss_evt      = accept_evt && !lk_hit;
  assign walk_done_evt = (state_q == ST_WALK) && walk_ack;
  assign fill_en       = walk_done_evt && walk_valid;
  assign fill_idx      = lk_hit ? match_idx : victim_idx;
  assign rr_advance    = fill_en && !lk_hit && !any_free;

  tlb_entry_array #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W),
    .CTX_W   (CTX_W)
  ) u_array (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_vpn       (lk_vpn),
    .lk_ctx       (lk_ctx),
    .match_vec    (match_vec),
    .valid_vec    (valid_vec),
    .hit_ppn      (hit_ppn),
    .hit_rights   (hit_rights),
    .fill_en      (fill_en),
    .fill_idx     (fill_idx),
    .fill_vpn     (pend_vpn_q),
    .fill_ctx     (pend_ctx_q),
    .fill_ppn     (walk_ppn),
    .fill_rights  (walk_rights),
    .flush_all    (flush_all),
    .flush_ctx_en (flush_ctx_en),
    .flush_ctx_id (flush_ctx_id)
  );

  tlb_victim_sel #(
    .ENTRIES (ENTRIES)
  ) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_vec  (valid_vec),
    .advance    (rr_advance),
    .any_free   (any_free),
    .victim_idx (victim_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pend_vpn_q  <= '0;
      pend_ctx_q  <= '0;
      pend_kind_q <= '0;
    end else begin
      if (miss_evt) begin
        state_q     <= ST_WALK;
        pend_vpn_q  <= req_vpn;
        pend_ctx_q  <= req_ctx;
        pend_kind_q <= req_kind;
      end else if (walk_done_evt) begin
        state_q <= ST_IDLE;
      end
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign walk_req   = (state_q == ST_WALK);
  assign walk_vpn   = pend_vpn_q;
  assign walk_ctx   = pend_ctx_q;

  assign resp_valid = hit_evt || walk_done_evt;
  assign resp_hit   = hit_evt;
  assign resp_ppn   = hit_evt ? hit_ppn : walk_ppn;
  assign resp_fault = walk_done_evt && !walk_valid;
  assign resp_deny  = hit_evt ? !rights_allow(hit_rights, req_kind)
                              : (fill_en && !rights_allow(walk_rights, pend_kind_q));

  p_walk_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !walk_ack) |=> (walk_req && $stable(walk_vpn) && $stable(walk_ctx)));

  p_fill_installs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush_all && !flush_ctx_en) |=> valid_vec[$past(fill_idx)]);

  p_fault_no_install_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |=> ($countones(valid_vec) <= $past($countones(valid_vec))));

  p_busy_ignores_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !walk_ack) |=> $stable(pend_kind_q));

endmodule

// File: tb/ctx_tlb_test.sv
`timescale 1ns/1ps
module ctx_tlb_test;

  localparam int VPN_W = 20;
  localparam int PPN_W = 16;
  localparam int CTX_W = 4;
  localparam int ENT   = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [VPN_W-1:0] req_vpn = '0;
  logic [CTX_W-1:0] req_ctx = '0;
  logic [1:0]       req_kind = '0;
  logic             req_ready;
  logic             resp_valid, resp_hit, resp_fault, resp_deny;
  logic [PPN_W-1:0] resp_ppn;
  logic             walk_req;
  logic [VPN_W-1:0] walk_vpn;
  logic [CTX_W-1:0] walk_ctx;
  logic             walk_ack = 1'b0;
  logic             walk_valid = 1'b0;
  logic [PPN_W-1:0] walk_ppn = '0;
  logic [2:0]       walk_rights = '0;
  logic             flush_all = 1'b0;
  logic             flush_ctx_en = 1'b0;
  logic [CTX_W-1:0] flush_ctx_id = '0;

  int n_checks = 0;
  int n_fails  = 0;
  int walks    = 0;
  int wait_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ctx_tlb #(.ENTRIES(ENT), .VPN_W(VPN_W), .PPN_W(PPN_W), .CTX_W(CTX_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vpn(req_vpn), .req_ctx(req_ctx), .req_kind(req_kind),
    .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_ppn(resp_ppn),
    .resp_fault(resp_fault), .resp_deny(resp_deny),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_ctx(walk_ctx),
    .walk_ack(walk_ack), .walk_valid(walk_valid), .walk_ppn(walk_ppn),
    .walk_rights(walk_rights),
    .flush_all(flush_all), .flush_ctx_en(flush_ctx_en), .flush_ctx_id(flush_ctx_id)
  );

  // page table model
  function automatic logic [PPN_W-1:0] pt_ppn(input logic [VPN_W-1:0] v, input logic [CTX_W-1:0] c);
    return v[PPN_W-1:0] ^ {c, 12'h000} ^ 16'h0A50;
  endfunction
  function automatic logic pt_valid(input logic [VPN_W-1:0] v);
    return v[7:0] != 8'hEE;
  endfunction
  function automatic logic [2:0] pt_rights(input logic [VPN_W-1:0] v);
    return {v[1], v[0], 1'b1};
  endfunction
  function automatic logic allowed(input logic [2:0] r, input logic [1:0] k);
    if (k == 2'd3) return 1'b0;
    return r[k];
  endfunction

  // walker: answers three falling edges after a request appears
  always @(negedge clk) begin
    if (walk_ack) begin
      walk_ack = 1'b0;
      wait_cnt = 0;
    end else if (walk_req) begin
      if (wait_cnt == 2) begin
        walk_ack    = 1'b1;
        walk_valid  = pt_valid(walk_vpn);
        walk_ppn    = pt_ppn(walk_vpn, walk_ctx);
        walk_rights = pt_rights(walk_vpn);
        walks++;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [VPN_W-1:0] v, input logic [CTX_W-1:0] c, input logic [1:0] k,
                        output bit hit, output logic [PPN_W-1:0] ppn, output bit fault,
                        output bit deny, output int walked);
    int w0;
    bit got;
    w0 = walks; got = 0; hit = 0; ppn = '0; fault = 0; deny = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vpn = v; req_ctx = c; req_kind = k;
    #1;
    if (resp_valid) begin
      got = 1; hit = resp_hit; ppn = resp_ppn; fault = resp_fault; deny = resp_deny;
    end
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 20 && !got; i++) begin
      #1;
      if (resp_valid) begin
        got = 1; hit = resp_hit; ppn = resp_ppn; fault = resp_fault; deny = resp_deny;
      end else begin
        @(negedge clk);
      end
    end
    walked = walks - w0;
  endtask

  task automatic t_reset_r10();
    bit h, f, d; logic [PPN_W-1:0] p; int w;
    check(req_ready === 1'b1, "R10 ready after reset", req_ready, 1);
    check(resp_valid === 1'b0 && walk_req === 1'b0, "R10 quiet after reset",
          {resp_valid, walk_req}, 0);
    access(20'h00100, 4'd1, 2'd0, h, p, f, d, w);
    check(!h && w == 1, "R10 first lookup misses", w, 1);
    check(p == pt_ppn(20'h00100, 4'd1), "R2 miss returns walked ppn", p, pt_ppn(20'h00100, 4'd1));
  endtask

  task automatic t_hit_r1();
    bit h, f, d; logic [PPN_W-1:0] p; int w;
    access(20'h00100, 4'd1, 2'd0, h, p, f, d, w);
    check(h && w == 0, "R1 refilled page hits without walk", {h, w[7:0]}, 9'h100);
    check(p == pt_ppn(20'h00100, 4'd1), "R1 hit ppn", p, pt_ppn(20'h00100, 4'd1));
  endtask

  task automatic t_context_r3();
    bit h, f, d; logic [PPN_W-1:0] p; int w;
    access(20'h00100, 4'd2, 2'd0, h, p, f, d, w);
    check(!h && w == 1, "R3 other context misses", w, 1);
    check(p == pt_ppn(20'h00100, 4'd2), "R3 other context ppn", p, pt_ppn(20'h00100, 4'd2));
    access(20'h00100, 4'd1, 2'd0, h, p, f, d, w);
    check(h && p == pt_ppn(20'h00100, 4'd1), "R3 first context still hits", p, pt_ppn(20'h00100, 4'd1));
  endtask

  task automatic t_fault_r4();
    bit h, f, d; logic [PPN_W-1:0] p; int w;
    access(20'h002EE, 4'd1, 2'd0, h, p, f, d, w);
    check(f && w == 1, "R4 invalid entry faults", f, 1);
    access(20'h002EE, 4'd1, 2'd0, h, p, f, d, w);
    check(f && !h && w == 1, "R4 faulting page not installed", w, 1);
  endtask

  task automatic t_rights_r5();
    bit h, f, d; logic [PPN_W-1:0] p; int w;
    access(20'h00101, 4'd1, 2'd0, h, p, f, d, w);
    check(!d, "R5 read on miss allowed", d, 0);
    access(20'h00101, 4'd1, 2'd1, h, p, f, d, w);
    check(h && d == !allowed(pt_rights(20'h00101), 2'd1), "R5 write on hit", d, 0);
    access(20'h00101, 4'd1, 2'd2, h, p, f, d, w);
    check(h && d == !allowed(pt_rights(20'h00101), 2'd2), "R5 exec on hit denied", d, 1);
    access(20'h00101, 4'd1, 2'd3, h, p, f, d, w);
    check(h && d, "R5 reserved kind denied", d, 1);
    access(20'h00104, 4'd1, 2'd2, h, p, f, d, w);
    check(!h && d, "R5 exec denied on filled miss", d, 1);
  endtask

  task automatic t_busy_r11();
    int w0;
    bit got;
    logic [PPN_W-1:0] p;
    bit h, f, d; int w;
    w0 = walks; got = 0; p = '0;
    @(negedge clk);
    req_valid = 1'b1; req_vpn = 20'h00500; req_ctx = 4'd6; req_kind = 2'd0;
    @(negedge clk);
    req_vpn = 20'h00501;
    for (int i = 0; i < 20 && !got; i++) begin
      #1;
      check(req_ready == 1'b0, "R11 not ready while walking", req_ready, 0);
      check(walk_vpn == 20'h00500, "R2 walk address held", walk_vpn, 20'h00500);
      if (resp_valid) begin
        got = 1; p = resp_ppn; req_valid = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    check(got && p == pt_ppn(20'h00500, 4'd6), "R11 response for original request",
          p, pt_ppn(20'h00500, 4'd6));
    check(walks - w0 == 1, "R11 single walk", walks - w0, 1);
    access(20'h00501, 4'd6, 2'd0, h, p, f, d, w);
    check(!h && w == 1, "R11 ignored request not installed", w, 1);
  endtask

  task automatic t_flush_ctx_r8();
    bit h, f, d; logic [PPN_W-1:0] p; int w;
    access(20'h00200, 4'd3, 2'd0, h, p, f, d, w);
    access(20'h00200, 4'd4, 2'd0, h, p, f, d, w);
    @(negedge clk); flush_ctx_en = 1'b1; flush_ctx_id = 4'd3;
    @(negedge clk); flush_ctx_en = 1'b0;
    access(20'h00200, 4'd4, 2'd0, h, p, f, d, w);
    check(h && w == 0, "R8 other context survives flush", w, 0);
    access(20'h00200, 4'd3, 2'd0, h, p, f, d, w);
    check(!h && w == 1, "R8 flushed context misses", w, 1);
  endtask

  task automatic t_flush_all_r7();
    bit h, f, d; logic [PPN_W-1:0] p; int w;
    @(negedge clk); flush_all = 1'b1;
    @(negedge clk); flush_all = 1'b0;
    access(20'h00200, 4'd4, 2'd0, h, p, f, d, w);
    check(!h && w == 1, "R7 entry gone after flush all", w, 1);
    access(20'h00100, 4'd1, 2'd0, h, p, f, d, w);
    check(!h && w == 1, "R7 second entry gone after flush all", w, 1);
  endtask

  task automatic t_victim_r6();
    bit h, f, d; logic [PPN_W-1:0] p; int w;
    int misses;
    @(negedge clk); flush_all = 1'b1;
    @(negedge clk); flush_all = 1'b0;
    access(20'h00300, 4'd5, 2'd0, h, p, f, d, w);
    access(20'h00300, 4'd5, 2'd0, h, p, f, d, w);
    check(h && w == 0, "R9 repeated page hits", w, 0);
    for (int i = 1; i < ENT; i++) access(20'h00300 + i, 4'd5, 2'd0, h, p, f, d, w);
    misses = 0;
    for (int i = 0; i < ENT; i++) begin
      access(20'h00300 + i, 4'd5, 2'd0, h, p, f, d, w);
      if (!h) misses++;
    end
    check(misses == 0, "R9 all slots hold distinct pages", misses, 0);
    access(20'h00400, 4'd5, 2'd0, h, p, f, d, w);
    misses = 0;
    for (int i = 1; i < ENT; i++) begin
      access(20'h00300 + i, 4'd5, 2'd0, h, p, f, d, w);
      if (!h) misses++;
    end
    check(misses == 0, "R6 slots 1..15 untouched by first eviction", misses, 0);
    access(20'h00300, 4'd5, 2'd0, h, p, f, d, w);
    check(!h && w == 1, "R6 round-robin evicted slot 0", w, 1);
    access(20'h00400, 4'd5, 2'd0, h, p, f, d, w);
    check(h, "R6 newest page resident", h, 1);
    access(20'h00301, 4'd5, 2'd0, h, p, f, d, w);
    check(!h && w == 1, "R6 pointer advanced to slot 1", w, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(req_ready === 1'b1 && walk_req === 1'b0, "R10 state during reset", {req_ready, walk_req}, 2);
    rst_n = 1'b1;
    t_reset_r10();
    t_hit_r1();
    t_context_r3();
    t_fault_r4();
    t_rights_r5();
    t_busy_r11();
    t_flush_ctx_r8();
    t_flush_all_r7();
    t_victim_r6();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule